// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit widens the 16-bit offsets of a small CPU into a 23-bit physical address space. An ordinary access names its kind: data, stack-relative or instruction fetch. The unit then puts a segment value above the offset. Data accesses take one of two 8-bit segments packed in the data-base register, and offset bit 15 picks which one. Stack-relative accesses take the 7-bit stack segment kept in bits 14..8 of the status word. Fetches take the low seven bits of the program-counter high register. Ordinary accesses go straight through to the memory request pins in the same cycle.

The unit also owns the stack pointer. A push command lowers the pointer by two and then writes the supplied word at the new location. A pop command reads at the current location and raises the pointer by two once the read completes. Each command is a single bus transaction closed by a ready handshake. While a command is in flight, the unit reports busy and accepts nothing else. If push and pop arrive together, the push is carried out and a protocol-error pulse is given.

Top module: `seg_agu`

## Requirements
- R1: Data kind (acc_kind = 2'b00) with offset bit 15 = 1 gives address {db_in[15:8], offset[14:0]}.
- R2: Data kind with offset bit 15 = 0 gives address {db_in[7:0], offset[14:0]}.
- R3: Stack kind (acc_kind = 2'b01) gives address {sr_in[14:8], offset}. Status bit 15 has no effect on the address.
- R4: Fetch kind (acc_kind = 2'b10) gives address {pch_in[6:0], offset}. Kind 2'b11 raises no strobe. An idle access raises mem_rd when acc_we = 0 and mem_wr when acc_we = 1, in the same cycle. acc_ready equals mem_ready for an access that was started.
- R5: A push seen while idle lowers sp_out by 2 at the next edge. From the next cycle on, the unit drives mem_wr with address {sr_in[14:8], new sp} and the pushed word on mem_wdata.
- R6: A pop seen while idle drives mem_rd at {sr_in[14:8], sp} from the next cycle on. On the edge where mem_ready is high, pop_data takes mem_rdata, pop_valid pulses for one cycle and sp_out rises by 2.
- R7: While a push or pop waits with mem_ready low, the strobe, the address and sp_out hold steady, and busy stays high.
- R8: Push and pop asserted together while idle: only the push is carried out, and proto_err is high for exactly the following cycle.
- R9: While busy, push, pop, sp_load and ordinary accesses are ignored, and acc_ready stays low. Ordinary accesses are also held off, with no strobe, in any cycle where a push or pop is asserted.
- R10: After reset, sp_out is 0, busy is 0, proto_err is 0 and no strobe is raised.
- R11: sp_load while idle, with no push or pop, writes sp_wdata into the stack pointer at the next edge. The pointer wraps modulo 2^16 on push and pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| db_in | input | 16 | Data-base register (two 8-bit data segments) |
| sr_in | input | 16 | Status word; bits 14..8 are the stack segment |
| pch_in | input | 16 | Program-counter high register |
| acc_valid | input | 1 | Ordinary access request |
| acc_kind | input | 2 | 00 data, 01 stack, 10 fetch, 11 none |
| acc_we | input | 1 | Access is a write |
| acc_offset | input | 16 | 16-bit offset (program counter for fetch) |
| acc_wdata | input | 16 | Write data of an ordinary access |
| acc_ready | output | 1 | Ordinary access accepted by memory |
| push_cmd | input | 1 | Push command |
| pop_cmd | input | 1 | Pop command |
| push_data | input | 16 | Word to push |
| sp_load | input | 1 | Direct write of the stack pointer |
| sp_wdata | input | 16 | Value for sp_load |
| sp_out | output | 16 | Current stack pointer |
| pop_data | output | 16 | Word returned by the last pop |
| pop_valid | output | 1 | One-cycle pulse when pop_data is updated |
| busy | output | 1 | Push or pop in flight |
| proto_err | output | 1 | Push and pop collided |
| mem_addr | output | 23 | Physical address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Memory completes the transaction |
| mem_rdata | input | 16 | Read data |

## Verification
Push and pop can land in the same idle cycle. An ordinary access can also coincide with a stack command. The bench raises both commands on one falling edge while acc_valid is held high. It then checks four things: the pointer moved down by two and not up; the write strobe and not the read strobe appears; proto_err is high for exactly one cycle; and acc_ready stays low. A second collision is made while a push is stalled with mem_ready low. There, the late pop must leave no trace on the pointer once the push completes.

// File: rtl/seg_agu.sv
module seg_agu #(
  parameter int OFS_W = 16,
  parameter int SSEG_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [OFS_W-1:0]         db_in,
  input  logic [OFS_W-1:0]         sr_in,
  input  logic [OFS_W-1:0]         pch_in,
  input  logic                     acc_valid,
  input  logic [1:0]               acc_kind,
  input  logic                     acc_we,
  input  logic [OFS_W-1:0]         acc_offset,
  input  logic [OFS_W-1:0]         acc_wdata,
  output logic                     acc_ready,
  input  logic                     push_cmd,
  input  logic                     pop_cmd,
  input  logic [OFS_W-1:0]         push_data,
  input  logic                     sp_load,
  input  logic [OFS_W-1:0]         sp_wdata,
  output logic [OFS_W-1:0]         sp_out,
  output logic [OFS_W-1:0]         pop_data,
  output logic                     pop_valid,
  output logic                     busy,
  output logic                     proto_err,
  output logic [OFS_W+SSEG_W-1:0]  mem_addr,
  output logic                     mem_rd,
  output logic                     mem_wr,
  output logic [OFS_W-1:0]         mem_wdata,
  input  logic                     mem_ready,
  input  logic [OFS_W-1:0]         mem_rdata
);
  localparam int AW = OFS_W + SSEG_W;
  localparam int DSEG_W = AW - (OFS_W - 1);
  localparam logic [OFS_W-1:0] STEP = OFS_W'(2);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POP} st_t;
  st_t state;
  logic [OFS_W-1:0] sp, push_buf;
  logic [AW-1:0] acc_addr;
  logic [SSEG_W-1:0] sseg;

  wire idle    = (state == S_IDLE);
  wire do_push = idle & push_cmd;
  wire do_pop  = idle & pop_cmd & ~push_cmd;
  wire acc_go  = idle & acc_valid & ~push_cmd & ~pop_cmd & (acc_kind != 2'b11);

  assign sseg = sr_in[OFS_W-2 -: SSEG_W];

  always_comb begin
    case (acc_kind)
      2'b00: acc_addr = {acc_offset[OFS_W-1] ? db_in[OFS_W-1 -: DSEG_W] : db_in[DSEG_W-1:0],
                         acc_offset[OFS_W-2:0]};
      2'b01: acc_addr = {sseg, acc_offset};
      2'b10: acc_addr = {pch_in[SSEG_W-1:0], acc_offset};
      default: acc_addr = '0;
    endcase
  end

  assign mem_addr  = idle ? acc_addr : {sseg, sp};
  assign mem_rd    = (state == S_POP)  | (acc_go & ~acc_we);
  assign mem_wr    = (state == S_PUSH) | (acc_go & acc_we);
  assign mem_wdata = idle ? acc_wdata : push_buf;
  assign acc_ready = acc_go & mem_ready;
  assign busy      = ~idle;
  assign sp_out    = sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sp        <= '0;
      push_buf  <= '0;
      pop_data  <= '0;
      pop_valid <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      pop_valid <= 1'b0;
      proto_err <= idle & push_cmd & pop_cmd;
      case (state)
        S_IDLE: begin
          if (do_push) begin
            sp       <= sp - STEP;
            push_buf <= push_data;
            state    <= S_PUSH;
          end else if (do_pop) begin
            state <= S_POP;
          end else if (sp_load) begin
            sp <= sp_wdata;
          end
        end
        S_PUSH: if (mem_ready) state <= S_IDLE;
        S_POP: if (mem_ready) begin
          pop_data  <= mem_rdata;
          pop_valid <= 1'b1;
          sp        <= sp + STEP;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        push_cmd,
  input logic        busy,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        mem_ready,
  input logic [22:0] mem_addr,
  input logic [15:0] sr_in,
  input logic [15:0] sp_out,
  input logic        proto_err
);
  p_push_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && push_cmd) |=> (sp_out == $past(sp_out) - 16'd2) && mem_wr && !mem_rd);

  p_pop_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rd && mem_ready) |=> (sp_out == $past(sp_out) + 16'd2) && !busy);

  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ready) |=> busy && $stable(sp_out) && $stable(mem_rd) && $stable(mem_wr));

  p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (sp_out == $past(sp_out) - 16'd2) && mem_wr);

  p_stack_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_addr == {sr_in[14:8], sp_out}));

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

bind seg_agu seg_agu_chk u_chk (.*);

// File: tb/seg_agu_tb.sv
`timescale 1ns/1ps
module seg_agu_tb;
  logic clk = 0, rst_n = 0;
  logic [15:0] db_in = 16'hA53C, sr_in = 16'h9A00, pch_in = 16'h0045;
  logic acc_valid = 0, acc_we = 0, push_cmd = 0, pop_cmd = 0, sp_load = 0, mem_ready = 1;
  logic [1:0] acc_kind = 0;
  logic [15:0] acc_offset = 0, acc_wdata = 0, push_data = 0, sp_wdata = 0, mem_rdata = 0;
  logic acc_ready, pop_valid, busy, proto_err, mem_rd, mem_wr;
  logic [15:0] sp_out, pop_data, mem_wdata;
  logic [22:0] mem_addr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  seg_agu u_dut (.*);

  // {kind, we, offset, expected address}
  localparam logic [41:0] VEC [8] = '{
    {2'b00, 1'b0, 16'h8123, 23'h528123},
    {2'b00, 1'b0, 16'h7FFF, 23'h1E7FFF},
    {2'b00, 1'b1, 16'h0000, 23'h1E0000},
    {2'b00, 1'b1, 16'hFFFF, 23'h52FFFF},
    {2'b01, 1'b0, 16'h1234, 23'h1A1234},
    {2'b01, 1'b1, 16'hFFFE, 23'h1AFFFE},
    {2'b10, 1'b0, 16'h0100, 23'h450100},
    {2'b10, 1'b0, 16'hABCD, 23'h45ABCD}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(sp_out == 0 && !busy && !proto_err, "R10 reset state", {sp_out, 14'b0, busy, proto_err}, 0);
    chk(!mem_rd && !mem_wr, "R10 no strobe in reset", {mem_rd, mem_wr}, 0);
    rst_n = 1;
    step();
    chk(sp_out == 0 && !mem_rd && !mem_wr, "R10 after reset", {sp_out, mem_rd, mem_wr}, 0);

    acc_valid = 1;
    foreach (VEC[i]) begin
      {acc_kind, acc_we, acc_offset} = VEC[i][41:23];
      #1;
      chk(mem_addr == VEC[i][22:0],
          VEC[i][41:40] == 2'b00 ? (acc_offset[15] ? "R1 upper data seg" : "R2 lower data seg")
                                  : (VEC[i][41:40] == 2'b01 ? "R3 stack seg" : "R4 fetch seg"),
          mem_addr, VEC[i][22:0]);
      chk(mem_rd == !acc_we && mem_wr == acc_we && acc_ready, "R4 strobes", {mem_rd, mem_wr, acc_ready}, {!acc_we, acc_we, 1'b1});
      step();
    end
    acc_kind = 2'b11; #1;
    chk(!mem_rd && !mem_wr && !acc_ready, "R4 reserved kind", {mem_rd, mem_wr}, 0);
    acc_kind = 2'b01; acc_we = 0; mem_ready = 0; #1;
    chk(!acc_ready && mem_rd, "R4 acc_ready follows mem_ready", acc_ready, 0);
    mem_ready = 1; acc_valid = 0;

    sp_load = 1; sp_wdata = 16'h1000; step(); sp_load = 0;
    chk(sp_out == 16'h1000, "R11 sp_load", sp_out, 16'h1000);

    push_cmd = 1; push_data = 16'hBEEF; mem_ready = 0; step(); push_cmd = 0;
    chk(sp_out == 16'h0FFE && busy, "R5 pre-decrement", sp_out, 16'h0FFE);
    chk(mem_wr && !mem_rd && mem_addr == 23'h1A0FFE && mem_wdata == 16'hBEEF, "R5 push write", mem_addr, 23'h1A0FFE);
    pop_cmd = 1; sp_load = 1; sp_wdata = 16'h5555; acc_valid = 1; acc_kind = 2'b00; step();
    pop_cmd = 0; sp_load = 0;
    chk(busy && mem_wr && sp_out == 16'h0FFE && mem_addr == 23'h1A0FFE, "R7 wait holds", sp_out, 16'h0FFE);
    chk(!acc_ready && !proto_err, "R9 busy ignores", {acc_ready, proto_err}, 0);
    acc_valid = 0; mem_ready = 1; step();
    chk(!busy && !mem_wr && sp_out == 16'h0FFE, "R9 late pop ignored", sp_out, 16'h0FFE);

    pop_cmd = 1; mem_ready = 0; step(); pop_cmd = 0;
    chk(mem_rd && mem_addr == 23'h1A0FFE && sp_out == 16'h0FFE, "R6 pop read", mem_addr, 23'h1A0FFE);
    mem_ready = 1; mem_rdata = 16'hC0DE; step();
    chk(pop_valid && pop_data == 16'hC0DE && sp_out == 16'h1000 && !busy, "R6 pop done", {pop_data, sp_out}, {16'hC0DE, 16'h1000});
    step();
    chk(!pop_valid, "R6 pop_valid pulse", pop_valid, 0);

    acc_valid = 1; push_cmd = 1; pop_cmd = 1; push_data = 16'h1111; #1;
    chk(!acc_ready && !mem_rd && !mem_wr, "R9 access held off by command", {acc_ready, mem_rd, mem_wr}, 0);
    step(); push_cmd = 0; pop_cmd = 0; acc_valid = 0;
    chk(proto_err && sp_out == 16'h0FFE && mem_wr && !mem_rd, "R8 push wins", {proto_err, sp_out}, {1'b1, 16'h0FFE});
    step();
    chk(!proto_err && !busy, "R8 proto_err one cycle", proto_err, 0);

    sp_load = 1; sp_wdata = 16'h0000; step(); sp_load = 0;
    push_cmd = 1; step(); push_cmd = 0;
    chk(sp_out == 16'hFFFE && mem_addr == 23'h1AFFFE, "R11 wrap down", sp_out, 16'hFFFE);
    step(); pop_cmd = 1; step(); pop_cmd = 0; step();
    chk(sp_out == 16'h0000, "R11 wrap up", sp_out, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule